// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a main-memory port. It keeps a parameterised number of sets, each with two ways. Each way holds one block of several words. A processor word address is split into three fields. The low bits pick the word inside a block. The next bits pick the set. The remaining upper bits are kept as the tag. Both ways of the selected set are compared at the same time, and a match completes the access in the same cycle.

On a miss the controller picks a victim way inside the set. If that victim holds modified data, its whole block is first written to memory. The requested block is then fetched into the victim way as one transfer. The stalled access then completes as a hit. Writes update only the cached copy and mark the way dirty; memory sees the data only when the block is evicted. A write miss first loads the block and then merges the word. Replacement is true LRU between the two ways, kept as one recency bit per set.

Top module: `sa2c_cache`

## Requirements
- R1: After reset every way is invalid, `mem_req` is low, and the first access to any address is a miss that fetches a block.
- R2: The block address is `cpu_addr[ADDR_W-1:OFF_W]`. A block goes to set (block address mod SETS), so set = `cpu_addr[OFF_W +: IDX_W]`. A fill puts this block address on `mem_addr`. A write-back puts the victim's tag and the same set bits on `mem_addr`.
- R3: A hit raises `cpu_ready` in the cycle of the request and returns the addressed word on `cpu_rdata` without any memory transfer. After a fill completes, the stalled request hits on the next cycle.
- R4: Two blocks that map to the same set are held at once, one per way, and both hit.
- R5: A miss into a set whose ways are both valid evicts the way that was not accessed most recently.
- R6: An invalid way is filled before any valid way is evicted. Way 0 is used when both ways are invalid.
- R7: A dirty victim is written to memory (`mem_we`=1) as a full block carrying its latest data. This happens before the fill of the new block, and memory then returns that data on later fetches.
- R8: A clean victim is overwritten with no write-back transfer.
- R9: A write miss fetches the block, then writes the word into the cached copy. The other words of the block keep the values fetched from memory.
- R10: A write hit finishes in one cycle with no memory transfer and leaves memory unchanged until the block is evicted.
- R11: `cpu_ready` is low while `mem_req` is high. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`, and a transfer completes on a clock edge where `mem_req` and `mem_ack` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes on this edge |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_wdata | output | DATA_W*WORDS | Block written back |
| mem_ack | input | 1 | Memory accepts or returns a block |
| mem_rdata | input | DATA_W*WORDS | Block fetched |

## Verification
Any wrong state shows up at the ports. A wrong recency bit makes the next miss in that set evict the wrong way, so a later access to the surviving block stalls where it should hit. A lost dirty bit shows up only at eviction: no write-back happens, and a later fetch of that block returns stale words. A wrong valid or tag bit changes hit latency and can put wrong data on `cpu_rdata`. The bench therefore checks stall count, transfer count, transfer address and returned data for every access.

// File: rtl/sa2c_pkg.sv
package sa2c_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2
   } sa2c_state_e;

   localparam int NWAYS = 2;
endpackage

// File: rtl/sa2c_way_store.sv
module sa2c_way_store #(
   parameter int SETS   = 8,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [$clog2(SETS)-1:0]   idx,
   output logic [TAG_W-1:0]          rd_tag,
   output logic                      rd_valid,
   output logic                      rd_dirty,
   output logic [DATA_W*WORDS-1:0]   rd_line,
   input  logic                      fill_en,
   input  logic [TAG_W-1:0]          fill_tag,
   input  logic [DATA_W*WORDS-1:0]   fill_line,
   input  logic                      wr_en,
   input  logic [$clog2(WORDS)-1:0]  wr_off,
   input  logic [DATA_W-1:0]         wr_data
);
   localparam int LINE_W = DATA_W * WORDS;

   logic [LINE_W-1:0] line_q [SETS];
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [SETS-1:0]   valid_q;
   logic [SETS-1:0]   dirty_q;

   assign rd_tag   = tag_q[idx];
   assign rd_valid = valid_q[idx];
   assign rd_dirty = dirty_q[idx];
   assign rd_line  = line_q[idx];

   // state bits: reset clears presence and modification
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (wr_en) begin
         dirty_q[idx] <= 1'b1;
      end
   end

   // payload: no reset needed, guarded by valid
   always_ff @(posedge clk) begin
      if (fill_en) begin
         line_q[idx] <= fill_line;
         tag_q[idx]  <= fill_tag;
      end else if (wr_en) begin
         line_q[idx][int'(wr_off)*DATA_W +: DATA_W] <= wr_data;
      end
   end
endmodule

// File: rtl/sa2c_lru.sv
module sa2c_lru #(
   parameter int SETS = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(SETS)-1:0]  idx,
   input  logic                     touch_en,
   input  logic                     touch_way,
   input  logic                     valid0,
   input  logic                     valid1,
   output logic                     victim
);
   // one bit per set: the way used last; its partner's recency bit is the inverse
   logic [SETS-1:0] mru_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mru_q <= '0;
      else if (touch_en) mru_q[idx] <= touch_way;
   end

   always_comb begin
      if (!valid0)      victim = 1'b0;
      else if (!valid1) victim = 1'b1;
      else              victim = ~mru_q[idx];
   end
endmodule

// File: rtl/sa2c_ctrl.sv
module sa2c_ctrl
   import sa2c_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cpu_req,
   input  logic         hit,
   input  logic         victim_in,
   input  logic         victim_dirty,
   input  logic         mem_ack,
   output sa2c_state_e  state,
   output logic         vict_q
);
   sa2c_state_e state_q;

   assign state = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vict_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_req && !hit) begin
                  vict_q  <= victim_in;
                  state_q <= victim_dirty ? ST_WBACK : ST_FILL;
               end
            end
            ST_WBACK: if (mem_ack) state_q <= ST_FILL;
            ST_FILL:  if (mem_ack) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sa2c_cache.sv
module sa2c_cache
   import sa2c_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SETS   = 8,
   parameter int WORDS  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cpu_req,
   input  logic                            cpu_we,
   input  logic [ADDR_W-1:0]               cpu_addr,
   input  logic [DATA_W-1:0]               cpu_wdata,
   output logic                            cpu_ready,
   output logic [DATA_W-1:0]               cpu_rdata,
   output logic                            mem_req,
   output logic                            mem_we,
   output logic [ADDR_W-$clog2(WORDS)-1:0] mem_addr,
   output logic [DATA_W*WORDS-1:0]         mem_wdata,
   input  logic                            mem_ack,
   input  logic [DATA_W*WORDS-1:0]         mem_rdata
);
   localparam int OFF_W  = $clog2(WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int LINE_W = DATA_W * WORDS;

   // elaboration-time parameter checks
   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if ((1 << OFF_W) != WORDS || WORDS < 2) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too narrow for SETS and WORDS");
   end

   logic [OFF_W-1:0] cpu_off;
   logic [IDX_W-1:0] cpu_idx;
   logic [TAG_W-1:0] cpu_tag;
   assign cpu_off = cpu_addr[OFF_W-1:0];
   assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
   assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

   logic [TAG_W-1:0]  way_tag   [NWAYS];
   logic [LINE_W-1:0] way_line  [NWAYS];
   logic [NWAYS-1:0]  way_valid;
   logic [NWAYS-1:0]  way_dirty;
   logic [NWAYS-1:0]  hit_vec;

   sa2c_state_e state;
   logic        vict_q;
   logic        victim;
   logic        hit;
   logic        hit_way;
   logic        in_idle;
   logic        fill_done;
   logic        write_hit;

   assign in_idle   = (state == ST_IDLE);
   assign hit       = |hit_vec;
   assign hit_way   = hit_vec[1];
   assign fill_done = (state == ST_FILL) && mem_ack;
   assign write_hit = in_idle && cpu_req && cpu_we && hit;

   // one store and one tag comparator per way
   for (genvar g = 0; g < NWAYS; g++) begin : g_way
      sa2c_way_store #(
         .SETS  (SETS),
         .WORDS (WORDS),
         .DATA_W(DATA_W),
         .TAG_W (TAG_W)
      ) u_store (
         .clk      (clk),
         .rst_n    (rst_n),
         .idx      (cpu_idx),
         .rd_tag   (way_tag[g]),
         .rd_valid (way_valid[g]),
         .rd_dirty (way_dirty[g]),
         .rd_line  (way_line[g]),
         .fill_en  (fill_done && (vict_q == 1'(g))),
         .fill_tag (cpu_tag),
         .fill_line(mem_rdata),
         .wr_en    (write_hit && hit_vec[g]),
         .wr_off   (cpu_off),
         .wr_data  (cpu_wdata)
      );
      assign hit_vec[g] = way_valid[g] && (way_tag[g] == cpu_tag);
   end

   sa2c_lru #(.SETS(SETS)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (cpu_idx),
      .touch_en (cpu_ready),
      .touch_way(hit_way),
      .valid0   (way_valid[0]),
      .valid1   (way_valid[1]),
      .victim   (victim)
   );

   sa2c_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_req     (cpu_req),
      .hit         (hit),
      .victim_in   (victim),
      .victim_dirty(way_valid[victim] && way_dirty[victim]),
      .mem_ack     (mem_ack),
      .state       (state),
      .vict_q      (vict_q)
   );

   assign cpu_ready = in_idle && cpu_req && hit;
   assign cpu_rdata = way_line[hit_way][int'(cpu_off)*DATA_W +: DATA_W];

   assign mem_req   = !in_idle;
   assign mem_we    = (state == ST_WBACK);
   assign mem_addr  = mem_we ? {way_tag[vict_q], cpu_idx} : {cpu_tag, cpu_idx};
   assign mem_wdata = way_line[vict_q];
endmodule

// File: rtl/sa2c_checker.sv
module sa2c_checker #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 2,
   parameter int IDX_W  = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       cpu_addr,
   input logic                    cpu_ready,
   input logic                    mem_req,
   input logic                    mem_we,
   input logic [ADDR_W-OFF_W-1:0] mem_addr,
   input logic                    mem_ack
);
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !mem_req);

   p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

   p_fill_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr == cpu_addr[ADDR_W-1:OFF_W]));

   p_wb_same_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr[IDX_W-1:0] == cpu_addr[OFF_W +: IDX_W]));

   p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

   p_fill_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (!mem_req && cpu_ready));
endmodule

bind sa2c_cache sa2c_checker #(
   .ADDR_W(ADDR_W),
   .OFF_W (OFF_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_addr (cpu_addr),
   .cpu_ready(cpu_ready),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_ack  (mem_ack)
);

// File: tb/tb_sa2c_cache.sv
module tb_sa2c_cache;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int SETS   = 8;
   localparam int WORDS  = 4;
   localparam int OFF_W  = 2;
   localparam int LINE_W = DATA_W * WORDS;
   localparam int NBLK   = 64;

   typedef struct packed {
      logic        we;
      logic [15:0] addr;
      logic [31:0] wdata;
      logic        exp_hit;
      logic        exp_wb;
      logic [7:0]  wb_blk;
   } vec_t;

   // word address = block*4 + word; set = block mod 8
   localparam int NVEC = 16;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 16'd4,   32'h0,         1'b0, 1'b0, 8'd0},  // blk1 miss, way0   R1 R2 R6
      '{1'b0, 16'd7,   32'h0,         1'b1, 1'b0, 8'd0},  // blk1 hit          R3
      '{1'b0, 16'd37,  32'h0,         1'b0, 1'b0, 8'd0},  // blk9 miss, way1   R6
      '{1'b0, 16'd6,   32'h0,         1'b1, 1'b0, 8'd0},  // blk1 still held   R4
      '{1'b1, 16'd38,  32'h11112222,  1'b1, 1'b0, 8'd0},  // write hit blk9    R10
      '{1'b0, 16'd68,  32'h0,         1'b0, 1'b0, 8'd0},  // blk17 evicts blk1 clean R5 R8
      '{1'b0, 16'd38,  32'h0,         1'b1, 1'b0, 8'd0},  // blk9 kept         R5
      '{1'b0, 16'd4,   32'h0,         1'b0, 1'b0, 8'd0},  // blk1 evicts blk17 R5
      '{1'b0, 16'd101, 32'h0,         1'b0, 1'b1, 8'd9},  // blk25 evicts dirty blk9 R7
      '{1'b0, 16'd38,  32'h0,         1'b0, 1'b0, 8'd0},  // blk9 refetched    R7
      '{1'b1, 16'd9,   32'hCAFE0001,  1'b0, 1'b0, 8'd0},  // write miss blk2   R9
      '{1'b0, 16'd9,   32'h0,         1'b1, 1'b0, 8'd0},  // merged word       R9
      '{1'b0, 16'd8,   32'h0,         1'b1, 1'b0, 8'd0},  // fetched word      R9
      '{1'b0, 16'd40,  32'h0,         1'b0, 1'b0, 8'd0},  // blk10 into way1   R6
      '{1'b0, 16'd72,  32'h0,         1'b0, 1'b1, 8'd2},  // blk18 evicts dirty blk2 R7
      '{1'b0, 16'd9,   32'h0,         1'b0, 1'b0, 8'd0}   // blk2 refetched    R7
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    cpu_req = 1'b0;
   logic                    cpu_we = 1'b0;
   logic [ADDR_W-1:0]       cpu_addr = '0;
   logic [DATA_W-1:0]       cpu_wdata = '0;
   logic                    cpu_ready;
   logic [DATA_W-1:0]       cpu_rdata;
   logic                    mem_req;
   logic                    mem_we;
   logic [ADDR_W-OFF_W-1:0] mem_addr;
   logic [LINE_W-1:0]       mem_wdata;
   logic                    mem_ack = 1'b0;
   logic [LINE_W-1:0]       mem_rdata = '0;

   sa2c_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [LINE_W-1:0] mem_model [NBLK];
   logic [LINE_W-1:0] ref_model [NBLK];
   int                wb_cnt = 0;
   int                fill_cnt = 0;
   int                last_wb_blk = -1;
   logic [LINE_W-1:0] last_wb_d = '0;

   function automatic logic [LINE_W-1:0] init_line(int blk);
      logic [LINE_W-1:0] l;
      for (int w = 0; w < WORDS; w++) l[w*DATA_W +: DATA_W] = {8'hA5, 8'(blk), 8'h00, 8'(w)};
      return l;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory responder: ack after two waiting cycles, one whole block per transfer
   initial begin
      logic             cap_we;
      int               cap_a;
      logic [LINE_W-1:0] cap_d;
      int               wcnt;
      cap_we = 1'b0; cap_a = 0; cap_d = '0; wcnt = 0;
      for (int b = 0; b < NBLK; b++) begin
         mem_model[b] = init_line(b);
         ref_model[b] = init_line(b);
      end
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            if (cap_we) begin
               mem_model[cap_a] = cap_d;
               wb_cnt++;
               last_wb_blk = cap_a;
               last_wb_d = cap_d;
            end else begin
               fill_cnt++;
            end
            mem_ack = 1'b0;
            wcnt = 0;
         end else if (mem_req && rst_n) begin
            wcnt++;
            if (wcnt >= 2) begin
               cap_we = mem_we;
               cap_a  = int'(mem_addr) % NBLK;
               cap_d  = mem_wdata;
               mem_rdata = mem_model[cap_a];
               mem_ack = 1'b1;
            end
         end else begin
            wcnt = 0;
         end
      end
   end

   // one processor access, started and ended at a falling edge
   task automatic access(input logic we, input logic [15:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd, output int stalls);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      stalls = 0;
      #1;
      while (!cpu_ready && stalls < 60) begin
         @(negedge clk); #1;
         if (mem_req && cpu_ready) check(1'b0, "R11 ready during transfer", 1, 0);
         stalls++;
      end
      rd = cpu_rdata;
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0;
      cpu_we  = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // full access with bookkeeping: hit expectation, transfer counts, data
   task automatic run_one(input logic we, input logic [15:0] addr, input logic [31:0] wd,
                          input bit exp_hit, input bit exp_wb, input int wb_blk, input string tag);
      logic [31:0] rd;
      int st, f0, w0, blk, wi;
      f0 = fill_cnt; w0 = wb_cnt;
      blk = int'(addr) / WORDS;
      wi  = int'(addr) % WORDS;
      access(we, addr, wd, rd, st);
      check((st == 0) == exp_hit, {tag, " hit/stall"}, st, exp_hit ? 0 : 1);
      check(fill_cnt - f0 == (exp_hit ? 0 : 1), {tag, " fetch count"}, fill_cnt - f0, exp_hit ? 0 : 1);
      check(wb_cnt - w0 == (exp_wb ? 1 : 0), {tag, " write-back count"}, wb_cnt - w0, exp_wb ? 1 : 0);
      if (exp_wb) begin
         check(last_wb_blk == wb_blk, {tag, " R2 write-back address"}, last_wb_blk, wb_blk);
         check(last_wb_d == ref_model[wb_blk], {tag, " R7 write-back data"}, last_wb_d, ref_model[wb_blk]);
      end
      if (we) begin
         ref_model[blk][wi*DATA_W +: DATA_W] = wd;
      end else begin
         check(rd == ref_model[blk][wi*DATA_W +: DATA_W], {tag, " read data"}, rd,
               ref_model[blk][wi*DATA_W +: DATA_W]);
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R11 watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int st, f0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(mem_req == 1'b0, "R1 mem_req low in reset", mem_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_req == 1'b0 && cpu_ready == 1'b0, "R1 idle after reset", {mem_req, cpu_ready}, 0);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
      for (int i = 0; i < NVEC; i++) begin
         run_one(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].exp_hit, VECS[i].exp_wb,
                 int'(VECS[i].wb_blk), $sformatf("vec%0d", i));
      end

      // R10: write hit to blk18 word3 leaves memory untouched
      run_one(1'b1, 16'd75, 32'h5555AAAA, 1'b1, 1'b0, 0, "R10 write hit");
      check(mem_model[18] == init_line(18), "R10 memory unchanged", mem_model[18], init_line(18));

      // R1: reset mid-run clears every way (dirty blk18 is dropped)
      do_reset();
      check(mem_req == 1'b0, "R1 mem_req low after reset", mem_req, 0);
      ref_model[18] = mem_model[18];
      f0 = fill_cnt;
      access(1'b0, 16'd9, 32'h0, rd, st);
      check(st > 0 && fill_cnt - f0 == 1, "R1 held block misses after reset", st, 1);
      check(rd == 32'hCAFE0001, "R7 written-back word refetched", rd, 32'hCAFE0001);

      // R6/R5: fill order then LRU in set 2 (blk2 way0, blk10 way1)
      run_one(1'b0, 16'd41, 32'h0, 1'b0, 1'b0, 0, "R6 second way filled");
      run_one(1'b0, 16'd10, 32'h0, 1'b1, 1'b0, 0, "R4 first way kept");
      run_one(1'b0, 16'd73, 32'h0, 1'b0, 1'b0, 0, "R5 evict lru blk10");
      run_one(1'b0, 16'd11, 32'h0, 1'b1, 1'b0, 0, "R5 recent blk2 survives");
      run_one(1'b0, 16'd42, 32'h0, 1'b0, 1'b0, 0, "R8 clean blk10 back");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule